// File: doc/BRIEF.md
# Speculative Transaction Tracking Controller

This block follows the memory footprint of one hardware thread while it runs a best-effort transaction with lazy versioning. Software opens a transaction with a begin command that carries a fail address, and the block then records every cache line the thread loads (read set) and stores (write set). Speculative data stays in the cache. The block keeps only the line addresses, and the write-set list acts as the commit log.

A commit of the outermost transaction drains the logged lines, one per handshake, to a memory write port and then ends with a done pulse. Several events abort the transaction: a coherence invalidation that hits a tracked line, a store or load that finds its set full, an interrupt or exception, a translation miss, a mispredicted control transfer, or an explicit software abort. On abort the block discards both sets, pulses a redirect carrying the saved fail address, and latches a cause code. Software reads that code and makes all retry and fallback decisions.

Top module: `txn_track_ctrl`

## Requirements
- R1: A begin in the idle state makes `active_o` high and `depth_o` 1 from the next cycle. It clears `cause_o` to 0 and captures `fail_pc_i` as the fail address.
- R2: A store to a line not yet in the write set adds that line. A store to a line already present adds nothing. After the outermost commit, `wb_valid_o` presents each logged line exactly once, in first-store order. Each line advances on a cycle with `wb_ready_i` high and is held stable while `wb_ready_i` is low.
- R3: The write set holds 16 lines when `big_buf_i`=0 and 32 when it is 1. The read set holds 8 lines. A store or load to a new line when its set is full aborts with cause 2. A repeat access to a present line never aborts.
- R4: While active, a `snoop_inv_i` whose `snoop_addr_i` matches a read-set or write-set line aborts with cause 1. A snoop to any other line has no effect.
- R5: While active, `trap_i` aborts with cause 3, `tlb_miss_i` with 4, `mispred_i` with 5 and `abort_i` with 6. When several occur together, priority is trap, then translation, then mispredict, then conflict, then software, then capacity.
- R6: Every abort gives a one-cycle `redirect_o` pulse in the cycle after the event, with `redirect_pc_o` equal to the outermost fail address. `active_o` drops, and the write set is discarded, so a following store-free commit emits no write-back.
- R7: `done_o` pulses for one cycle after the last write-back handshake. A commit with an empty write set gives `done_o` in the next cycle with no `wb_valid_o`.
- R8: While draining, begin, snoop, trap, translation, mispredict and software-abort inputs have no effect. Every line is written, no redirect occurs, `cause_o` stays 0, and the block is idle afterwards.
- R9: Nesting is flat. A begin while active increments `depth_o` and keeps the tracked sets. An inner commit only decrements it. Only the outermost commit starts the drain. An abort at any depth redirects to the outermost fail address.
- R10: `cause_o` holds the last abort code until the next outermost begin. Abort sources, loads, stores and snoops are ignored while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| big_buf_i | input | 1 | Static write-set size select: 0 = 16 lines, 1 = 32 lines |
| begin_i | input | 1 | Begin-transaction command |
| fail_pc_i | input | PC_W | Fail address carried by begin |
| commit_i | input | 1 | Commit command |
| abort_i | input | 1 | Explicit software abort |
| ld_valid_i | input | 1 | Load notification |
| st_valid_i | input | 1 | Store notification |
| line_addr_i | input | LINE_AW | Cache-line address of the load or store |
| snoop_inv_i | input | 1 | Coherence invalidation snoop |
| snoop_addr_i | input | LINE_AW | Line address of the snoop |
| trap_i | input | 1 | Interrupt or exception |
| tlb_miss_i | input | 1 | Translation miss |
| mispred_i | input | 1 | Mispredicted control transfer |
| wb_ready_i | input | 1 | Write port accepts the presented line |
| active_o | output | 1 | Transaction in progress |
| depth_o | output | NEST_W | Flat nesting count |
| redirect_o | output | 1 | One-cycle abort redirect pulse |
| redirect_pc_o | output | PC_W | Redirect target (outermost fail address) |
| cause_o | output | 3 | Abort cause: 0 none, 1 conflict, 2 capacity, 3 trap, 4 translation, 5 mispredict, 6 software |
| wb_valid_o | output | 1 | Write-back line presented |
| wb_addr_o | output | LINE_AW | Write-back line address |
| done_o | output | 1 | One-cycle commit-complete pulse |

## Verification
The bound checker watches the cycle-level rules on every cycle:
- the redirect target matches the fail address latched at the outermost begin, and a redirect only follows an active cycle with a nonzero cause;
- the write-back address holds while the port stalls;
- a drain ends only in done, never in redirect;
- the nesting count agrees with the active flag;
- a begin from idle lands in the active state with a cleared cause.

The directed scenarios cover what needs a history:
- deduplication and first-store ordering of the drained lines;
- the exact capacity boundary for each buffer size and for the read set;
- which snoop addresses conflict;
- the cause priority between simultaneous events;
- the discarding of the commit log after an abort;
- the immunity of the drain to late events.

// File: rtl/txn_pkg.sv
package txn_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACTIVE, ST_DRAIN} txn_state_e;

  typedef enum logic [2:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_CONFLICT = 3'd1,
    CAUSE_CAPACITY = 3'd2,
    CAUSE_TRAP     = 3'd3,
    CAUSE_XLAT     = 3'd4,
    CAUSE_CTI      = 3'd5,
    CAUSE_SW       = 3'd6
  } txn_cause_e;
endpackage

// File: rtl/txn_set.sv
// Associative list of line addresses: dedup insert, snoop lookup, indexed read.
module txn_set #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = 26,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          ins_i,
  input  logic [AW-1:0] ins_addr_i,
  input  logic [AW-1:0] look_addr_i,
  input  logic [CW-1:0] cap_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic          ins_hit_o,
  output logic          look_hit_o,
  output logic          full_o,
  output logic [CW-1:0] cnt_o,
  output logic [AW-1:0] rd_addr_o
);
  logic [AW-1:0]    ent_q [DEPTH];
  logic [CW-1:0]    cnt_q;
  logic [DEPTH-1:0] hit_ins, hit_look;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic vld;
    assign vld         = CW'(g) < cnt_q;
    assign hit_ins[g]  = vld && (ent_q[g] == ins_addr_i);
    assign hit_look[g] = vld && (ent_q[g] == look_addr_i);
  end

  assign ins_hit_o  = |hit_ins;
  assign look_hit_o = |hit_look;
  assign full_o     = cnt_q >= cap_i;
  assign cnt_o      = cnt_q;
  assign rd_addr_o  = ent_q[rd_idx_i];

  logic do_ins;
  assign do_ins = ins_i && !ins_hit_o && !full_o && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (do_ins) cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i) begin
    if (do_ins) ent_q[cnt_q[IW-1:0]] <= ins_addr_i;
  end
endmodule

// File: rtl/txn_cause_sel.sv
// Fixed-priority abort cause encoder.
module txn_cause_sel
  import txn_pkg::*;
(
  input  logic       trap_i,
  input  logic       xlat_i,
  input  logic       cti_i,
  input  logic       conflict_i,
  input  logic       sw_i,
  input  logic       capacity_i,
  output logic       abort_o,
  output txn_cause_e cause_o
);
  always_comb begin
    if (trap_i)          cause_o = CAUSE_TRAP;
    else if (xlat_i)     cause_o = CAUSE_XLAT;
    else if (cti_i)      cause_o = CAUSE_CTI;
    else if (conflict_i) cause_o = CAUSE_CONFLICT;
    else if (sw_i)       cause_o = CAUSE_SW;
    else if (capacity_i) cause_o = CAUSE_CAPACITY;
    else                 cause_o = CAUSE_NONE;
  end
  assign abort_o = trap_i | xlat_i | cti_i | conflict_i | sw_i | capacity_i;
endmodule

// File: rtl/txn_track_ctrl.sv
module txn_track_ctrl
  import txn_pkg::*;
#(
  parameter int unsigned LINE_AW  = 26,
  parameter int unsigned PC_W     = 32,
  parameter int unsigned WR_BIG   = 32,
  parameter int unsigned WR_SMALL = 16,
  parameter int unsigned RD_DEPTH = 8,
  parameter int unsigned NEST_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               big_buf_i,
  input  logic               begin_i,
  input  logic [PC_W-1:0]    fail_pc_i,
  input  logic               commit_i,
  input  logic               abort_i,
  input  logic               ld_valid_i,
  input  logic               st_valid_i,
  input  logic [LINE_AW-1:0] line_addr_i,
  input  logic               snoop_inv_i,
  input  logic [LINE_AW-1:0] snoop_addr_i,
  input  logic               trap_i,
  input  logic               tlb_miss_i,
  input  logic               mispred_i,
  input  logic               wb_ready_i,
  output logic               active_o,
  output logic [NEST_W-1:0]  depth_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    redirect_pc_o,
  output logic [2:0]         cause_o,
  output logic               wb_valid_o,
  output logic [LINE_AW-1:0] wb_addr_o,
  output logic               done_o
);
  localparam int unsigned WCW = $clog2(WR_BIG + 1);
  localparam int unsigned WIW = $clog2(WR_BIG);
  localparam int unsigned RCW = $clog2(RD_DEPTH + 1);
  localparam int unsigned RIW = $clog2(RD_DEPTH);

  txn_state_e        state_q;
  txn_cause_e        cause_q, sel_cause;
  logic [NEST_W-1:0] depth_q;
  logic [PC_W-1:0]   fail_pc_q;
  logic              redirect_q, done_q;
  logic [WIW-1:0]    drain_idx_q;

  logic is_idle, is_act, is_drain;
  assign is_idle  = state_q == ST_IDLE;
  assign is_act   = state_q == ST_ACTIVE;
  assign is_drain = state_q == ST_DRAIN;

  logic               rs_ins_hit, rs_look_hit, rs_full;
  logic [RCW-1:0]     rs_cnt_unused;
  logic [LINE_AW-1:0] rs_addr_unused;
  logic               ws_ins_hit, ws_look_hit, ws_full;
  logic [WCW-1:0]     ws_cnt, ws_cap;
  logic [LINE_AW-1:0] ws_rd_addr;

  logic abort_now, conflict, cap_ev, rs_ins, ws_ins, ws_new, set_clr, drain_last;

  assign ws_cap   = big_buf_i ? WCW'(WR_BIG) : WCW'(WR_SMALL);
  assign conflict = is_act && snoop_inv_i && (rs_look_hit || ws_look_hit);
  assign cap_ev   = is_act && ((ld_valid_i && !rs_ins_hit && rs_full) ||
                               (st_valid_i && !ws_ins_hit && ws_full));

  txn_cause_sel u_cause (
    .trap_i     (is_act && trap_i),
    .xlat_i     (is_act && tlb_miss_i),
    .cti_i      (is_act && mispred_i),
    .conflict_i (conflict),
    .sw_i       (is_act && abort_i),
    .capacity_i (cap_ev),
    .abort_o    (abort_now),
    .cause_o    (sel_cause)
  );

  assign rs_ins     = is_act && ld_valid_i && !abort_now;
  assign ws_ins     = is_act && st_valid_i && !abort_now;
  assign ws_new     = ws_ins && !ws_ins_hit;
  assign drain_last = (WCW'(drain_idx_q) + WCW'(1)) == ws_cnt;
  assign set_clr    = (is_idle && begin_i) || abort_now ||
                      (is_drain && wb_ready_i && drain_last);

  txn_set #(.DEPTH(RD_DEPTH), .AW(LINE_AW)) u_rd_set (
    .clk_i, .rst_ni,
    .clr_i       (set_clr),
    .ins_i       (rs_ins),
    .ins_addr_i  (line_addr_i),
    .look_addr_i (snoop_addr_i),
    .cap_i       (RCW'(RD_DEPTH)),
    .rd_idx_i    ({RIW{1'b0}}),
    .ins_hit_o   (rs_ins_hit),
    .look_hit_o  (rs_look_hit),
    .full_o      (rs_full),
    .cnt_o       (rs_cnt_unused),
    .rd_addr_o   (rs_addr_unused)
  );

  txn_set #(.DEPTH(WR_BIG), .AW(LINE_AW)) u_wr_set (
    .clk_i, .rst_ni,
    .clr_i       (set_clr),
    .ins_i       (ws_ins),
    .ins_addr_i  (line_addr_i),
    .look_addr_i (snoop_addr_i),
    .cap_i       (ws_cap),
    .rd_idx_i    (drain_idx_q),
    .ins_hit_o   (ws_ins_hit),
    .look_hit_o  (ws_look_hit),
    .full_o      (ws_full),
    .cnt_o       (ws_cnt),
    .rd_addr_o   (ws_rd_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cause_q     <= CAUSE_NONE;
      depth_q     <= '0;
      fail_pc_q   <= '0;
      redirect_q  <= 1'b0;
      done_q      <= 1'b0;
      drain_idx_q <= '0;
    end else begin
      redirect_q <= 1'b0;
      done_q     <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (begin_i) begin
          state_q   <= ST_ACTIVE;
          depth_q   <= NEST_W'(1);
          fail_pc_q <= fail_pc_i;
          cause_q   <= CAUSE_NONE;
        end
        ST_ACTIVE: begin
          if (abort_now) begin
            state_q    <= ST_IDLE;
            depth_q    <= '0;
            redirect_q <= 1'b1;
            cause_q    <= sel_cause;
          end else if (commit_i && !begin_i) begin
            if (depth_q > NEST_W'(1)) begin
              depth_q <= depth_q - NEST_W'(1);
            end else begin
              depth_q <= '0;
              // a store in the commit cycle is still logged and drained
              if (ws_cnt != '0 || ws_new) begin
                state_q     <= ST_DRAIN;
                drain_idx_q <= '0;
              end else begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
            end
          end else if (begin_i && !commit_i && depth_q != '1) begin
            depth_q <= depth_q + NEST_W'(1);
          end
        end
        ST_DRAIN: if (wb_ready_i) begin
          if (drain_last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            drain_idx_q <= drain_idx_q + WIW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign active_o      = is_act;
  assign depth_o       = depth_q;
  assign redirect_o    = redirect_q;
  assign redirect_pc_o = fail_pc_q;
  assign cause_o       = cause_q;
  assign wb_valid_o    = is_drain;
  assign wb_addr_o     = ws_rd_addr;
  assign done_o        = done_q;
endmodule

// File: rtl/txn_track_ctrl_chk.sv
module txn_track_ctrl_chk #(
  parameter int unsigned LINE_AW = 26,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned NEST_W  = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               begin_i,
  input logic [PC_W-1:0]    fail_pc_i,
  input logic               wb_ready_i,
  input logic               active_o,
  input logic [NEST_W-1:0]  depth_o,
  input logic               redirect_o,
  input logic [PC_W-1:0]    redirect_pc_o,
  input logic [2:0]         cause_o,
  input logic               wb_valid_o,
  input logic [LINE_AW-1:0] wb_addr_o,
  input logic               done_o
);
  logic [PC_W-1:0] exp_pc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exp_pc_q <= '0;
    else if (begin_i && !active_o && !wb_valid_o) exp_pc_q <= fail_pc_i;
  end

  assert_begin_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (begin_i && !active_o && !wb_valid_o) |=> (active_o && depth_o == NEST_W'(1) && cause_o == 3'd0));

  assert_wb_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && !wb_ready_i) |=> (wb_valid_o && $stable(wb_addr_o)));

  assert_cause_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (cause_o != 3'd0 && cause_o <= 3'd6));

  assert_redirect_pc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (redirect_pc_o == exp_pc_q));

  assert_redirect_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (!active_o && $past(active_o)));

  assert_done_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!active_o && !wb_valid_o && !redirect_o && $past(active_o || wb_valid_o)));

  assert_drain_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> (!redirect_o && (wb_valid_o || done_o)));

  assert_depth_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o == (depth_o != '0));
endmodule

bind txn_track_ctrl txn_track_ctrl_chk #(
  .LINE_AW(LINE_AW), .PC_W(PC_W), .NEST_W(NEST_W)
) chk_i (
  .clk_i, .rst_ni, .begin_i, .fail_pc_i, .wb_ready_i, .active_o, .depth_o,
  .redirect_o, .redirect_pc_o, .cause_o, .wb_valid_o, .wb_addr_o, .done_o
);

// File: tb/txn_track_ctrl_tb_top.sv
`timescale 1ns/1ps
module txn_track_ctrl_tb_top;
  localparam int AW = 26;
  localparam int PW = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic big_buf_i = 1'b0, begin_i = 1'b0, commit_i = 1'b0, abort_i = 1'b0;
  logic [PW-1:0] fail_pc_i = '0;
  logic ld_valid_i = 1'b0, st_valid_i = 1'b0, snoop_inv_i = 1'b0;
  logic [AW-1:0] line_addr_i = '0, snoop_addr_i = '0;
  logic trap_i = 1'b0, tlb_miss_i = 1'b0, mispred_i = 1'b0, wb_ready_i = 1'b1;
  logic active_o, redirect_o, wb_valid_o, done_o;
  logic [2:0] depth_o, cause_o;
  logic [PW-1:0] redirect_pc_o;
  logic [AW-1:0] wb_addr_o;

  always #4 clk_i = ~clk_i;

  txn_track_ctrl dut_i (.*);

  int total = 0, bad = 0;
  logic [AW-1:0] got [64];
  int got_n;
  bit saw_redirect;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk_i); endtask

  task automatic do_begin(logic [PW-1:0] pc);
    begin_i = 1; fail_pc_i = pc; cyc(); begin_i = 0;
  endtask
  task automatic do_commit(); commit_i = 1; cyc(); commit_i = 0; endtask
  task automatic do_store(logic [AW-1:0] a);
    st_valid_i = 1; line_addr_i = a; cyc(); st_valid_i = 0;
  endtask
  task automatic do_load(logic [AW-1:0] a);
    ld_valid_i = 1; line_addr_i = a; cyc(); ld_valid_i = 0;
  endtask
  task automatic do_snoop(logic [AW-1:0] a);
    snoop_inv_i = 1; snoop_addr_i = a; cyc(); snoop_inv_i = 0;
  endtask
  task automatic do_ev(bit tr, bit tl, bit mp, bit sw);
    trap_i = tr; tlb_miss_i = tl; mispred_i = mp; abort_i = sw; cyc();
    trap_i = 0; tlb_miss_i = 0; mispred_i = 0; abort_i = 0;
  endtask

  // collect write-backs until done_o; optional stalls and late noise
  task automatic collect(bit stall, bit noise);
    got_n = 0; saw_redirect = 0;
    for (int k = 0; k < 300; k++) begin
      if (redirect_o) saw_redirect = 1;
      if (done_o) break;
      wb_ready_i = stall ? k[0] : 1'b1;
      if (noise) begin
        begin_i = 1; fail_pc_i = 32'hDEAD; trap_i = 1; tlb_miss_i = 1;
        mispred_i = 1; abort_i = 1; snoop_inv_i = 1; snoop_addr_i = 26'h31;
      end
      if (wb_valid_o && wb_ready_i && got_n < 64) begin
        got[got_n] = wb_addr_o; got_n++;
      end
      cyc();
    end
    begin_i = 0; trap_i = 0; tlb_miss_i = 0; mispred_i = 0; abort_i = 0;
    snoop_inv_i = 0; wb_ready_i = 1;
  endtask

  task automatic chk_abort(string req, logic [2:0] cause, logic [PW-1:0] pc);
    chk({req, " redirect"}, redirect_o, 1);
    chk({req, " cause"}, cause_o, cause);
    chk({req, " pc"}, redirect_pc_o, pc);
    chk({req, " inactive"}, active_o, 0);
    cyc();
    chk({req, " pulse"}, redirect_o, 0);
  endtask

  task automatic t_reset();
    chk("R1 reset active", active_o, 0);
    chk("R1 reset depth", depth_o, 0);
    chk("R10 reset cause", cause_o, 0);
    chk("R6 reset redirect", redirect_o, 0);
    chk("R7 reset done", done_o, 0);
    chk("R2 reset wb", wb_valid_o, 0);
  endtask

  task automatic t_dedup();
    do_begin(32'h100);
    chk("R1 active", active_o, 1);
    chk("R1 depth", depth_o, 1);
    do_store(5); do_store(9); do_store(5); do_load(3); do_store(7);
    do_commit();
    chk("R2 drain start", wb_valid_o, 1);
    collect(0, 0);
    chk("R2 dedup count", got_n, 3);
    chk("R2 order0", got[0], 5);
    chk("R2 order1", got[1], 9);
    chk("R2 order2", got[2], 7);
    chk("R7 done", done_o, 1);
    chk("R10 cause after success", cause_o, 0);
    cyc();
    chk("R7 done pulse", done_o, 0);
  endtask

  task automatic t_stall();
    do_begin(32'h110);
    for (int i = 0; i < 6; i++) do_store(AW'(20 + i));
    do_commit();
    collect(1, 0);
    chk("R2 stall count", got_n, 6);
    for (int i = 0; i < 6; i++) chk("R2 stall order", got[i], AW'(20 + i));
    chk("R7 stall done", done_o, 1);
    cyc();
  endtask

  task automatic t_empty_commit();
    do_begin(32'h120);
    do_load(1);
    do_commit();
    chk("R7 empty done", done_o, 1);
    chk("R7 empty no wb", wb_valid_o, 0);
    cyc();
  endtask

  task automatic t_capacity(bit big, int lim);
    big_buf_i = big;
    do_begin(32'h200 + PW'(lim));
    for (int i = 0; i < lim; i++) do_store(AW'(100 + i));
    chk("R3 full still active", active_o, 1);
    do_store(100);
    chk("R3 repeat at full", active_o, 1);
    do_store(AW'(999));
    chk_abort("R3 overflow", 3'd2, 32'h200 + PW'(lim));
    do_begin(32'h210);
    do_commit();
    chk("R6 log discarded", done_o, 1);
    chk("R6 log discarded wb", wb_valid_o, 0);
    cyc();
    big_buf_i = 0;
  endtask

  task automatic t_read_cap();
    do_begin(32'h220);
    for (int i = 0; i < 8; i++) do_load(AW'(300 + i));
    do_load(300);
    chk("R3 read repeat at full", active_o, 1);
    do_load(AW'(400));
    chk_abort("R3 read overflow", 3'd2, 32'h220);
  endtask

  task automatic t_snoop();
    do_begin(32'h300);
    do_load(40); do_store(50);
    do_snoop(60);
    chk("R4 unrelated snoop", active_o, 1);
    chk("R4 unrelated no redirect", redirect_o, 0);
    do_snoop(40);
    chk_abort("R4 read-set hit", 3'd1, 32'h300);
    do_begin(32'h310);
    do_store(50);
    do_snoop(50);
    chk_abort("R4 write-set hit", 3'd1, 32'h310);
  endtask

  task automatic t_events();
    do_begin(32'h400); do_ev(1, 0, 0, 0); chk_abort("R5 trap", 3'd3, 32'h400);
    do_begin(32'h401); do_ev(0, 1, 0, 0); chk_abort("R5 tlb", 3'd4, 32'h401);
    do_begin(32'h402); do_ev(0, 0, 1, 0); chk_abort("R5 mispredict", 3'd5, 32'h402);
    do_begin(32'h403); do_ev(0, 0, 0, 1); chk_abort("R5 software", 3'd6, 32'h403);
    // priority cases
    do_begin(32'h410); do_load(70);
    snoop_inv_i = 1; snoop_addr_i = 70; do_ev(1, 0, 1, 0); snoop_inv_i = 0;
    chk_abort("R5 prio trap", 3'd3, 32'h410);
    do_begin(32'h411); do_ev(0, 1, 1, 1);
    chk_abort("R5 prio tlb", 3'd4, 32'h411);
    do_begin(32'h412); do_load(71);
    snoop_inv_i = 1; snoop_addr_i = 71; do_ev(0, 0, 0, 1); snoop_inv_i = 0;
    chk_abort("R5 prio conflict", 3'd1, 32'h412);
    do_begin(32'h413);
    for (int i = 0; i < 8; i++) do_load(AW'(500 + i));
    ld_valid_i = 1; line_addr_i = 600; do_ev(0, 0, 0, 1); ld_valid_i = 0;
    chk_abort("R5 prio sw over capacity", 3'd6, 32'h413);
  endtask

  task automatic t_nest();
    do_begin(32'h500);
    do_store(1);
    do_begin(32'h501);
    chk("R9 depth2", depth_o, 2);
    do_store(2);
    do_commit();
    chk("R9 inner commit active", active_o, 1);
    chk("R9 inner commit depth", depth_o, 1);
    chk("R9 inner commit no drain", wb_valid_o, 0);
    do_commit();
    collect(0, 0);
    chk("R9 outer drain count", got_n, 2);
    chk("R9 tracking kept", got[0], 1);
    chk("R9 tracking kept 2", got[1], 2);
    cyc();
    do_begin(32'h600); do_begin(32'h700);
    do_ev(0, 0, 1, 0);
    chk_abort("R9 nested abort", 3'd5, 32'h600);
  endtask

  task automatic t_drain_noise();
    do_begin(32'h800);
    do_store(AW'(49)); do_store(AW'(33)); do_store(AW'(17));
    do_commit();
    collect(1, 1);
    chk("R8 all lines", got_n, 3);
    chk("R8 line0", got[0], 49);
    chk("R8 line2", got[2], 17);
    chk("R8 no redirect", saw_redirect, 0);
    chk("R8 done", done_o, 1);
    chk("R8 cause clear", cause_o, 0);
    cyc();
    chk("R8 idle after", active_o, 0);
    chk("R8 depth after", depth_o, 0);
  endtask

  task automatic t_idle_hold();
    do_begin(32'h900); do_ev(0, 0, 0, 1);
    chk_abort("R10 abort", 3'd6, 32'h900);
    do_ev(1, 1, 1, 1);
    do_snoop(5); do_store(5); do_load(6);
    chk("R10 idle ignores", redirect_o, 0);
    chk("R10 idle stays", active_o, 0);
    chk("R10 cause held", cause_o, 6);
    do_commit();
    chk("R10 idle commit ignored", done_o, 0);
    do_begin(32'h910);
    chk("R10 cause cleared by begin", cause_o, 0);
    do_commit();
    chk("R10 clean commit", done_o, 1);
    cyc();
  endtask

  initial begin
    repeat (3) cyc();
    rst_ni = 1;
    cyc();
    t_reset();
    t_dedup();
    t_stall();
    t_empty_commit();
    t_capacity(0, 16);
    t_capacity(1, 32);
    t_read_cap();
    t_snoop();
    t_events();
    t_nest();
    t_drain_noise();
    t_idle_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule